// File: doc/BRIEF.md
# ECP Reverse-Channel Host Receiver

This block is the host-side engine that pulls bytes from a peripheral over a parallel port running in ECP mode. When the host logic asks for reverse traffic, the block turns its own data-bus driver off and only then lowers its reverse-request line. It does not accept any byte until the peripheral lowers its reverse-acknowledge line. In the reverse direction the peripheral frames every byte with its strobe line. The block answers each strobe by raising its acknowledge line, and it latches the data lines on the strobe's rising edge.

Each received byte leaves on a valid/ready stream with a flag that tells a data byte from a command byte. The peripheral sets the tag through the level of its acknowledge line. While the stream stalls, the block holds its acknowledge high, so the peripheral cannot present the next byte. All peripheral inputs are synchronized to the host clock. A request to go back to forward direction is honoured only between bytes. The host bus driver comes back on only after the peripheral has released its reverse-acknowledge line.

Top module: `ecp_rev_rx`

## Requirements
- R1: While rst_ni is low: rev_req_no=1, data_oe_o=1, host_ack_o=0, m_valid_o=0, rev_active_o=0.
- R2: After rev_en_i rises, data_oe_o goes to 0 at least one clock before rev_req_no goes to 0. data_oe_o stays 0 for as long as rev_req_no is 0.
- R3: Until the synchronized ack_rev_ni has been seen at 0, rev_active_o stays 0 and a low periph_clk_ni does not raise host_ack_o. Once ack_rev_ni is 0, rev_active_o becomes 1.
- R4: In reverse mode, a low level on periph_clk_ni makes host_ack_o go to 1.
- R5: After periph_clk_ni returns to 1, the block raises m_valid_o and m_data_o carries the value that data_i held across the strobe.
- R6: m_cmd_o is the inverse of the level periph_ack_i held during the strobe. periph_ack_i=1 marks a data byte (m_cmd_o=0). periph_ack_i=0 marks a command byte (m_cmd_o=1).
- R7: While m_valid_o=1 and m_ready_i=0, m_valid_o, m_data_o and m_cmd_o hold steady and host_ack_o stays 1.
- R8: In the clock after a byte is taken (m_valid_o and m_ready_i both 1), m_valid_o and host_ack_o are 0.
- R9: When rev_en_i falls, rev_req_no returns to 1 only while host_ack_o is 0. data_oe_o returns to 1 only after ack_rev_ni has gone back to 1.
- R10: periph_req_o is the inverse of periph_req_ni, delayed by the two synchronizer stages.
- R11: In forward mode, strobes on periph_clk_ni are ignored: host_ack_o and m_valid_o stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rev_en_i | input | 1 | 1 requests reverse direction, 0 requests forward |
| periph_clk_ni | input | 1 | Peripheral byte strobe, low while the byte is valid |
| periph_ack_i | input | 1 | Peripheral acknowledge line, carries the byte tag |
| ack_rev_ni | input | 1 | Peripheral grant of reverse direction, active low |
| periph_req_ni | input | 1 | Peripheral has reverse data, active low |
| data_i | input | DATA_W | Data lines as seen by the host |
| host_ack_o | output | 1 | Host acknowledge line level |
| rev_req_no | output | 1 | Reverse request, active low |
| data_oe_o | output | 1 | Host data-bus driver enable |
| rev_active_o | output | 1 | Reverse direction granted |
| periph_req_o | output | 1 | Synchronized reverse-data-available status |
| m_valid_o | output | 1 | Output byte valid |
| m_ready_i | input | 1 | Output consumer ready |
| m_data_o | output | DATA_W | Received byte |
| m_cmd_o | output | 1 | 1 for a command byte, 0 for a data byte |

## Verification
The bound checker checks four relations on every cycle. The bus driver is off whenever reverse request is low and before it falls. Acknowledge is raised only while reverse is granted. A stalled output holds its byte and keeps acknowledge high. Release of reverse request falls only between bytes, and the driver re-enables only with the request released. Only the bench's scenarios show the rest. That covers the byte values and tags that arrive, the ignoring of strobes before the grant or in forward mode, and the status pass-through. It also covers the order of the return sequence against the peripheral's release.

// File: rtl/ecp_rev_pkg.sv
package ecp_rev_pkg;
  typedef enum logic [2:0] {
    DIR_FWD,
    DIR_TRI,
    DIR_REQ,
    DIR_REV,
    DIR_RET
  } dir_state_e;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_ACK,
    RX_HOLD
  } rx_state_e;
endpackage

// File: rtl/ecp_sync.sv
module ecp_sync #(
  parameter int unsigned         W       = 1,
  parameter int unsigned         STAGES  = 2,
  parameter logic [W-1:0]        RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[g] <= RST_VAL;
        else         stg[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[g] <= RST_VAL;
        else         stg[g] <= stg[g-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/ecp_dir_ctrl.sv
module ecp_dir_ctrl
  import ecp_rev_pkg::*;
#(
  parameter int unsigned TRI_CYCLES = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rev_en_i,
  input  logic ack_rev_ns_i,
  input  logic rx_busy_i,
  output logic rev_req_no,
  output logic data_oe_o,
  output logic rev_active_o,
  output logic rx_en_o
);
  localparam int unsigned CW = $clog2(TRI_CYCLES + 1);

  dir_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      DIR_FWD: if (rev_en_i) begin
        state_d = DIR_TRI;
        cnt_d   = '0;
      end
      DIR_TRI: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CW'(TRI_CYCLES - 1)) state_d = DIR_REQ;
      end
      DIR_REQ: begin
        if (!rev_en_i)          state_d = DIR_RET;
        else if (!ack_rev_ns_i) state_d = DIR_REV;
      end
      DIR_REV: if (!rev_en_i && !rx_busy_i) state_d = DIR_RET;
      // wait for peripheral to release the bus before driving again
      DIR_RET: if (ack_rev_ns_i) state_d = DIR_FWD;
      default: state_d = DIR_FWD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= DIR_FWD;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign rev_req_no   = !(state_q == DIR_REQ || state_q == DIR_REV);
  assign data_oe_o    = (state_q == DIR_FWD);
  assign rev_active_o = (state_q == DIR_REV);
  assign rx_en_o      = (state_q == DIR_REV) && rev_en_i;
endmodule

// File: rtl/ecp_byte_rx.sv
module ecp_byte_rx
  import ecp_rev_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic              pclk_ns_i,
  input  logic              tag_s_i,
  input  logic [DATA_W-1:0] data_s_i,
  output logic              host_ack_o,
  output logic              busy_o,
  output logic              m_valid_o,
  input  logic              m_ready_i,
  output logic [DATA_W-1:0] m_data_o,
  output logic              m_cmd_o
);
  rx_state_e state_q, state_d;
  logic [DATA_W-1:0] data_d_q, data_q;
  logic              tag_d_q, cmd_q;
  logic              cap;

  always_comb begin
    state_d = state_q;
    cap     = 1'b0;
    unique case (state_q)
      RX_IDLE: if (rx_en_i && !pclk_ns_i) state_d = RX_ACK;
      // strobe was low on entry, so high here is its rising edge
      RX_ACK: if (pclk_ns_i) begin
        state_d = RX_HOLD;
        cap     = 1'b1;
      end
      RX_HOLD: if (m_ready_i) state_d = RX_IDLE;
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= RX_IDLE;
      data_d_q <= '0;
      tag_d_q  <= 1'b0;
      data_q   <= '0;
      cmd_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      data_d_q <= data_s_i;
      tag_d_q  <= tag_s_i;
      if (cap) begin
        data_q <= data_d_q;
        cmd_q  <= !tag_d_q;
      end
    end
  end

  assign host_ack_o = (state_q != RX_IDLE);
  assign busy_o     = (state_q != RX_IDLE);
  assign m_valid_o  = (state_q == RX_HOLD);
  assign m_data_o   = data_q;
  assign m_cmd_o    = cmd_q;
endmodule

// File: rtl/ecp_rev_rx.sv
module ecp_rev_rx #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TRI_CYCLES  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rev_en_i,
  input  logic              periph_clk_ni,
  input  logic              periph_ack_i,
  input  logic              ack_rev_ni,
  input  logic              periph_req_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic              host_ack_o,
  output logic              rev_req_no,
  output logic              data_oe_o,
  output logic              rev_active_o,
  output logic              periph_req_o,
  output logic              m_valid_o,
  input  logic              m_ready_i,
  output logic [DATA_W-1:0] m_data_o,
  output logic              m_cmd_o
);
  localparam int unsigned SW = DATA_W + 4;
  localparam logic [SW-1:0] SRST = {1'b1, 1'b0, 1'b1, 1'b1, {DATA_W{1'b0}}};

  logic [SW-1:0]     sync_q;
  logic              pclk_ns, tag_s, ack_rev_ns, preq_ns;
  logic [DATA_W-1:0] data_s;
  logic              rx_en, rx_busy;

  ecp_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SRST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({periph_clk_ni, periph_ack_i, ack_rev_ni, periph_req_ni, data_i}),
    .q_o   (sync_q)
  );

  assign {pclk_ns, tag_s, ack_rev_ns, preq_ns, data_s} = sync_q;
  assign periph_req_o = !preq_ns;

  ecp_dir_ctrl #(.TRI_CYCLES(TRI_CYCLES)) u_dir (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rev_en_i    (rev_en_i),
    .ack_rev_ns_i(ack_rev_ns),
    .rx_busy_i   (rx_busy),
    .rev_req_no  (rev_req_no),
    .data_oe_o   (data_oe_o),
    .rev_active_o(rev_active_o),
    .rx_en_o     (rx_en)
  );

  ecp_byte_rx #(.DATA_W(DATA_W)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rx_en_i   (rx_en),
    .pclk_ns_i (pclk_ns),
    .tag_s_i   (tag_s),
    .data_s_i  (data_s),
    .host_ack_o(host_ack_o),
    .busy_o    (rx_busy),
    .m_valid_o (m_valid_o),
    .m_ready_i (m_ready_i),
    .m_data_o  (m_data_o),
    .m_cmd_o   (m_cmd_o)
  );
endmodule

// File: rtl/ecp_rev_rx_chk.sv
module ecp_rev_rx_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              host_ack_o,
  input logic              rev_req_no,
  input logic              data_oe_o,
  input logic              rev_active_o,
  input logic              m_valid_o,
  input logic              m_ready_i,
  input logic [DATA_W-1:0] m_data_o,
  input logic              m_cmd_o
);
  // R2
  oe_off_in_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rev_req_no |-> !data_oe_o);

  // R2
  tri_before_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rev_req_no) |-> $past(!data_oe_o));

  // R3
  ack_needs_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_ack_o |-> rev_active_o);

  // R7
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_valid_o && !m_ready_i) |=> (m_valid_o && $stable(m_data_o) && $stable(m_cmd_o)));

  // R7
  ack_while_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_valid_o |-> host_ack_o);

  // R9
  release_between_bytes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rev_req_no) |-> !host_ack_o);

  // R9
  oe_back_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_oe_o) |-> rev_req_no);
endmodule

bind ecp_rev_rx ecp_rev_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .host_ack_o  (host_ack_o),
  .rev_req_no  (rev_req_no),
  .data_oe_o   (data_oe_o),
  .rev_active_o(rev_active_o),
  .m_valid_o   (m_valid_o),
  .m_ready_i   (m_ready_i),
  .m_data_o    (m_data_o),
  .m_cmd_o     (m_cmd_o)
);

// File: tb/tb_ecp_rev_rx.sv
module tb_ecp_rev_rx;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rev_en_i = 1'b0;
  logic       periph_clk_ni = 1'b1;
  logic       periph_ack_i = 1'b0;
  logic       ack_rev_ni = 1'b1;
  logic       periph_req_ni = 1'b1;
  logic [7:0] data_i = 8'h00;
  logic       m_ready_i = 1'b1;
  logic       host_ack_o, rev_req_no, data_oe_o, rev_active_o, periph_req_o;
  logic       m_valid_o, m_cmd_o;
  logic [7:0] m_data_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk_i = ~clk_i;

  ecp_rev_rx dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .rev_en_i(rev_en_i),
    .periph_clk_ni(periph_clk_ni), .periph_ack_i(periph_ack_i),
    .ack_rev_ni(ack_rev_ni), .periph_req_ni(periph_req_ni), .data_i(data_i),
    .host_ack_o(host_ack_o), .rev_req_no(rev_req_no), .data_oe_o(data_oe_o),
    .rev_active_o(rev_active_o), .periph_req_o(periph_req_o),
    .m_valid_o(m_valid_o), .m_ready_i(m_ready_i), .m_data_o(m_data_o),
    .m_cmd_o(m_cmd_o)
  );

  // {tag, data}: tag 1 = data byte, 0 = command byte
  localparam logic [8:0] VEC [6] = '{
    {1'b1, 8'hA5}, {1'b0, 8'h3C}, {1'b1, 8'h00},
    {1'b1, 8'hFF}, {1'b0, 8'h81}, {1'b0, 8'h5A}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wait_ack(input logic lvl, output bit ok);
    ok = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      if (host_ack_o === lvl) begin ok = 1; break; end
    end
  endtask

  task automatic wait_valid(output bit ok);
    ok = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      if (m_valid_o === 1'b1) begin ok = 1; break; end
    end
  endtask

  // peripheral drives one byte up to the strobe rising edge
  task automatic strobe(input logic [7:0] d, input logic tag);
    bit ok;
    data_i = d;
    periph_ack_i = tag;
    cyc(2);
    periph_clk_ni = 1'b0;
    wait_ack(1'b1, ok);
    chk("R4 host_ack rise", 32'(ok), 32'd1);
    periph_clk_ni = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit ok;
    cyc(3);
    // R1 reset state
    chk("R1 rev_req_no", 32'(rev_req_no), 32'd1);
    chk("R1 data_oe_o", 32'(data_oe_o), 32'd1);
    chk("R1 host_ack_o", 32'(host_ack_o), 32'd0);
    chk("R1 m_valid_o", 32'(m_valid_o), 32'd0);
    chk("R1 rev_active_o", 32'(rev_active_o), 32'd0);
    rst_ni = 1'b1;
    cyc(2);

    // R11 strobe in forward mode ignored
    periph_clk_ni = 1'b0;
    cyc(6);
    chk("R11 host_ack_o", 32'(host_ack_o), 32'd0);
    chk("R11 m_valid_o", 32'(m_valid_o), 32'd0);
    periph_clk_ni = 1'b1;
    cyc(4);
    chk("R11 m_valid_o after", 32'(m_valid_o), 32'd0);

    // R10 status pass-through
    periph_req_ni = 1'b0;
    cyc(1);
    chk("R10 not yet", 32'(periph_req_o), 32'd0);
    cyc(2);
    chk("R10 periph_req_o", 32'(periph_req_o), 32'd1);
    periph_req_ni = 1'b1;
    cyc(3);
    chk("R10 periph_req_o clear", 32'(periph_req_o), 32'd0);

    // R2 turnaround
    rev_en_i = 1'b1;
    cyc(1);
    chk("R2 oe off first", 32'(data_oe_o), 32'd0);
    chk("R2 req still high", 32'(rev_req_no), 32'd1);
    ok = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_i);
      if (rev_req_no === 1'b0) begin ok = 1; break; end
    end
    chk("R2 req low", 32'(ok), 32'd1);
    chk("R2 oe off in req", 32'(data_oe_o), 32'd0);

    // R3 no byte before grant
    periph_clk_ni = 1'b0;
    cyc(6);
    chk("R3 host_ack before grant", 32'(host_ack_o), 32'd0);
    chk("R3 not active", 32'(rev_active_o), 32'd0);
    periph_clk_ni = 1'b1;
    cyc(4);
    ack_rev_ni = 1'b0;
    cyc(4);
    chk("R3 active", 32'(rev_active_o), 32'd1);
    chk("R3 no stale byte", 32'(m_valid_o), 32'd0);

    // R5 R6 R8 table walk
    foreach (VEC[k]) begin
      strobe(VEC[k][7:0], VEC[k][8]);
      wait_valid(ok);
      chk("R5 valid", 32'(ok), 32'd1);
      chk("R5 data", 32'(m_data_o), 32'(VEC[k][7:0]));
      chk("R6 cmd", 32'(m_cmd_o), 32'(!VEC[k][8]));
      cyc(1);
      chk("R8 valid drop", 32'(m_valid_o), 32'd0);
      chk("R8 ack low", 32'(host_ack_o), 32'd0);
      data_i = ~VEC[k][7:0];
    end

    // R7 backpressure
    m_ready_i = 1'b0;
    strobe(8'hC3, 1'b0);
    wait_valid(ok);
    chk("R7 valid", 32'(ok), 32'd1);
    data_i = 8'h11;
    periph_ack_i = 1'b1;
    for (int i = 0; i < 5; i++) begin
      cyc(1);
      chk("R7 hold ack", 32'(host_ack_o), 32'd1);
      chk("R7 hold data", 32'(m_data_o), 32'hC3);
      chk("R7 hold cmd", 32'(m_cmd_o), 32'd1);
    end
    m_ready_i = 1'b1;
    cyc(1);
    chk("R8 after stall valid", 32'(m_valid_o), 32'd0);
    chk("R8 after stall ack", 32'(host_ack_o), 32'd0);

    // R9 return to forward
    rev_en_i = 1'b0;
    ok = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_i);
      if (rev_req_no === 1'b1) begin ok = 1; break; end
    end
    chk("R9 req released", 32'(ok), 32'd1);
    chk("R9 ack low at release", 32'(host_ack_o), 32'd0);
    cyc(4);
    chk("R9 oe waits grant release", 32'(data_oe_o), 32'd0);
    ack_rev_ni = 1'b1;
    ok = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_i);
      if (data_oe_o === 1'b1) begin ok = 1; break; end
    end
    chk("R9 oe back", 32'(ok), 32'd1);
    chk("R9 inactive", 32'(rev_active_o), 32'd0);

    // R1 reset again mid-operation
    rst_ni = 1'b0;
    cyc(1);
    chk("R1 reset oe", 32'(data_oe_o), 32'd1);
    chk("R1 reset ack", 32'(host_ack_o), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule